// File: doc/BRIEF.md
# Chained DMA Descriptor Sequencer

This block walks a linked list of transfer descriptors for a single DMA channel. A start pulse loads an initial pointer. The sequencer then reads a fixed number of consecutive words from descriptor memory through a synchronous read port with one cycle of latency. The first of these words is the chain pointer. The remaining words are the transfer parameters, which go unchanged to a separate transfer engine together with a one-pulse start strobe. When the engine signals completion, the sequencer decodes the chain pointer. It then either fetches the next descriptor or returns to idle.

The chain pointer word carries three fields: the next descriptor address, a per-descriptor interrupt flag, and a bit that tags the next descriptor as a data or a coefficient descriptor. The interrupt flag lets software choose between an interrupt after every descriptor and a single interrupt when the chain ends. Every interrupt request passes a mask. A request that gets through sets a pending flag, which software clears by writing one to a clear input.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset the sequencer is idle: `busy`, `irq_pending`, `mem_rd` and `xfer_start` are all 0.
- R2: A `start` pulse while idle reads DESC_WORDS words from addresses `init_ptr`+0 up to `init_ptr`+DESC_WORDS-1, one read per cycle, with the read data valid one cycle after `mem_rd`. Word 0 is the chain pointer. Word k (k >= 1) appears on `xfer_params` bits [(k-1)*DW +: DW].
- R3: `xfer_start` is a one-cycle pulse. It is asserted two cycles after the last `mem_rd` cycle of a fetch, and never while a read is outstanding. `xfer_params` holds steady until the transfer completes.
- R4: In the chain pointer, bits [AW-1:0] give the next descriptor address, bit AW is the interrupt-per-descriptor flag, and bit AW+1 is the type of the next descriptor (0 = data, 1 = coefficient). With the defaults these are bits 18:0, 19 and 20. `xfer_coeff` shows the type of the current descriptor. The first descriptor of a chain is always data type.
- R5: When chaining continues and the interrupt flag of the finished descriptor is 1, `irq_pending` becomes 1 in the same cycle as the read of word 0 of the next descriptor.
- R6: A descriptor whose flag is 0 and whose chain continues raises no interrupt. A next address of zero ends the chain: after that transfer completes the sequencer returns to idle, and `irq_pending` rises in the same cycle that `busy` falls.
- R7: With `chain_en` at 0, the sequencer runs one descriptor only, whatever its next address and flag. It reads no further words and raises a single end interrupt when it returns to idle.
- R8: While `irq_mask` is 1, interrupt requests do not set `irq_pending`.
- R9: `irq_clr` clears `irq_pending`. When a new request arrives in the same cycle as a clear, the pending flag stays set.
- R10: `start` is ignored while busy, and `xfer_done` is ignored outside the wait-for-completion state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a chain at `init_ptr` (only while idle) |
| init_ptr | input | AW | Address of the first descriptor |
| chain_en | input | 1 | 1 = follow chain pointers, 0 = run a single descriptor |
| irq_mask | input | 1 | 1 = drop interrupt requests |
| irq_clr | input | 1 | Write-one-to-clear for the pending interrupt |
| mem_rd | output | 1 | Descriptor memory read strobe |
| mem_addr | output | AW | Descriptor memory read address |
| mem_rdata | input | DW | Read data, valid one cycle after `mem_rd` |
| xfer_start | output | 1 | One-cycle start for the transfer engine |
| xfer_params | output | (DESC_WORDS-1)*DW | Descriptor words 1 and up |
| xfer_coeff | output | 1 | Type of the current descriptor (1 = coefficient) |
| xfer_done | input | 1 | Completion pulse from the transfer engine |
| busy | output | 1 | Sequencer is not idle |
| irq_pending | output | 1 | Latched interrupt |

## Verification
The bench builds the sequencer with AW=19 and DW=32, so the interrupt flag and type bit sit at bits 19 and 20 as in real use. It sets DESC_WORDS=4 instead of a shorter descriptor. The longer fetch gives four reads per descriptor and a wide three-word parameter bus, which lets the bench check the word-to-slice order and the two-cycle gap from the last read to the start strobe. It also leaves several fetch cycles in which stray `start` and `xfer_done` pulses can be injected.

// File: rtl/dma_chain_seq.sv
module dma_chain_seq #(
  parameter int AW         = 19,
  parameter int DW         = 32,
  parameter int DESC_WORDS = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [AW-1:0]                  init_ptr,
  input  logic                           chain_en,
  input  logic                           irq_mask,
  input  logic                           irq_clr,
  output logic                           mem_rd,
  output logic [AW-1:0]                  mem_addr,
  input  logic [DW-1:0]                  mem_rdata,
  output logic                           xfer_start,
  output logic [(DESC_WORDS-1)*DW-1:0]   xfer_params,
  output logic                           xfer_coeff,
  input  logic                           xfer_done,
  output logic                           busy,
  output logic                           irq_pending
);
  localparam int CW      = $clog2(DESC_WORDS + 1);
  localparam int PW      = (DESC_WORDS - 1) * DW;
  localparam int FLAG_B  = AW;
  localparam int TYPE_B  = AW + 1;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_RUN, S_NEXT} st_t;

  st_t            st;
  logic [AW-1:0]  ptr;
  logic [CW-1:0]  cnt;
  logic [AW-1:0]  link_addr;
  logic           link_flag;
  logic           link_type;
  logic [PW-1:0]  prm;
  logic           cur_type;

  wire go_on = chain_en && (link_addr != '0);
  wire req   = (st == S_NEXT) && (!go_on || link_flag);

  assign mem_rd      = (st == S_FETCH) && (cnt < CW'(DESC_WORDS));
  assign mem_addr    = ptr + AW'(cnt);
  assign busy        = (st != S_IDLE);
  assign xfer_params = prm;
  assign xfer_coeff  = cur_type;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      ptr        <= '0;
      cnt        <= '0;
      link_addr  <= '0;
      link_flag  <= 1'b0;
      link_type  <= 1'b0;
      prm        <= '0;
      cur_type   <= 1'b0;
      xfer_start <= 1'b0;
    end else begin
      xfer_start <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          st       <= S_FETCH;
          ptr      <= init_ptr;
          cnt      <= '0;
          cur_type <= 1'b0;
        end
        S_FETCH: begin
          if (cnt == CW'(1)) begin
            link_addr <= mem_rdata[AW-1:0];
            link_flag <= mem_rdata[FLAG_B];
            link_type <= mem_rdata[TYPE_B];
          end
          for (int k = 1; k < DESC_WORDS; k++)
            if (cnt == CW'(k + 1)) prm[(k-1)*DW +: DW] <= mem_rdata;
          if (cnt == CW'(DESC_WORDS)) begin
            st         <= S_RUN;
            xfer_start <= 1'b1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_RUN: if (xfer_done) st <= S_NEXT;
        S_NEXT: begin
          if (go_on) begin
            st       <= S_FETCH;
            ptr      <= link_addr;
            cnt      <= '0;
            cur_type <= link_type;
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_pending <= 1'b0;
    else        irq_pending <= (irq_pending && !irq_clr) || (req && !irq_mask);
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !xfer_start));

  assert_no_start_during_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !xfer_start);

  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  assert_params_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && !xfer_start) |-> $stable(xfer_params));

  assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_pending && irq_mask) |=> !irq_pending);

  assert_pending_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && !irq_clr) |=> irq_pending);
endmodule

// File: tb/test_dma_chain_seq.sv
module test_dma_chain_seq;
  localparam int AW = 19;
  localparam int DW = 32;
  localparam int NW = 4;
  localparam int PW = (NW - 1) * DW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, start, chain_en, irq_mask, irq_clr;
  logic [AW-1:0] init_ptr;
  logic          mem_rd, xfer_start, xfer_coeff, xfer_done, busy, irq_pending;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic [PW-1:0] xfer_params;

  dma_chain_seq #(.AW(AW), .DW(DW), .DESC_WORDS(NW)) i_dma_chain_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .init_ptr(init_ptr),
    .chain_en(chain_en), .irq_mask(irq_mask), .irq_clr(irq_clr),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .xfer_start(xfer_start), .xfer_params(xfer_params), .xfer_coeff(xfer_coeff),
    .xfer_done(xfer_done), .busy(busy), .irq_pending(irq_pending));

  logic [DW-1:0] mem [0:255];
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

  int checks = 0, errors = 0;
  logic [PW:0] exp_q[$];
  int cyc = 0, since = 1000, dly = 0, starts = 0, rises = 0, rds = 0;
  bit prev_pend = 0, rise_rd = 0, rise_busy = 0;
  logic [AW-1:0] rise_addr = '0;
  bit clr_req = 0, clr_at_next = 0, coll_chk = 0, force_done = 0;

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] cpw(int nxt, bit flag, bit typ);
    return DW'({typ, flag, AW'(nxt)});
  endfunction

  task automatic put_desc(int a, logic [DW-1:0] cp, int tag);
    mem[a] = cp;
    for (int k = 1; k < NW; k++) mem[a+k] = {16'(tag), 16'(k)};
  endtask

  task automatic expect_chain(int p, bit ce);
    bit typ = 0;
    for (int n = 0; n < 16; n++) begin
      int nx;
      exp_q.push_back({typ, mem[p+3], mem[p+2], mem[p+1]});
      nx = int'(mem[p][AW-1:0]);
      if (!ce || nx == 0) break;
      typ = mem[p][AW+1];
      p = nx;
    end
  endtask

  task automatic run_chain(int p, bit ce);
    expect_chain(p, ce);
    @(negedge clk);
    init_ptr = AW'(p); chain_en = ce; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_irq();
    clr_req = 1;
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 50000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (mem_rd) begin since = 0; rds++; end
    else if (since < 1000) since++;
    if (irq_pending && !prev_pend) begin
      rises++; rise_rd = mem_rd; rise_addr = mem_addr; rise_busy = busy;
    end
    prev_pend = irq_pending;
    if (coll_chk) begin
      chk(irq_pending == 1'b1, "R9 request beats clear", irq_pending, 1);
      coll_chk = 0;
    end
    if (xfer_start) begin
      starts++;
      chk(since == 2, "R3 start two cycles after last read", since, 2);
      if (exp_q.size() == 0) chk(0, "R10 unexpected transfer", xfer_params, 0);
      else begin
        logic [PW:0] e;
        e = exp_q.pop_front();
        chk({xfer_coeff, xfer_params} == e, "R2/R4 transfer params and type",
            {xfer_coeff, xfer_params}, e);
      end
      dly = 3;
    end
    xfer_done <= 1'b0;
    irq_clr   <= 1'b0;
    if (xfer_done && clr_at_next) begin irq_clr <= 1'b1; clr_at_next = 0; coll_chk = 1; end
    if (clr_req) begin irq_clr <= 1'b1; clr_req = 0; end
    if (dly > 0) begin if (dly == 1) xfer_done <= 1'b1; dly--; end
    if (force_done) begin xfer_done <= 1'b1; force_done = 0; end
  end

  initial begin
    int s0, r0;
    rst_n = 0; start = 0; chain_en = 0; irq_mask = 0; irq_clr = 0;
    init_ptr = '0; xfer_done = 0; mem_rdata = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !irq_pending && !mem_rd && !xfer_start, "R1 reset state",
        {busy, irq_pending, mem_rd, xfer_start}, 0);

    put_desc(8'h10, cpw(8'h20, 0, 1), 16'hA1);
    put_desc(8'h20, cpw(8'h30, 0, 0), 16'hB2);
    put_desc(8'h30, cpw(0, 0, 0), 16'hC3);

    // R6 / R4: three descriptors, flag clear, one end interrupt
    rises = 0; s0 = starts;
    run_chain(8'h10, 1);
    chk(starts - s0 == 3, "R6 three transfers", starts - s0, 3);
    chk(rises == 1, "R6 single end interrupt", rises, 1);
    chk(rise_busy == 0, "R6 interrupt as busy falls", rise_busy, 0);
    chk(exp_q.size() == 0, "R4 chain fully walked", exp_q.size(), 0);
    clear_irq();
    chk(irq_pending == 0, "R9 clear", irq_pending, 0);

    // R5: flag set on first descriptor
    mem[8'h10] = cpw(8'h20, 1, 1);
    rises = 0;
    run_chain(8'h10, 1);
    chk(rises == 1, "R5 one rise", rises, 1);
    chk(rise_rd == 1, "R5 rise with next fetch read", rise_rd, 1);
    chk(rise_addr == AW'(8'h20), "R5 rise at next word 0", rise_addr, 8'h20);
    chk(rise_busy == 1, "R5 rise mid chain", rise_busy, 1);
    clear_irq();

    // R7: chaining disabled
    rises = 0; s0 = starts; r0 = rds;
    run_chain(8'h10, 0);
    chk(starts - s0 == 1, "R7 single transfer", starts - s0, 1);
    chk(rds - r0 == NW, "R7 no further reads", rds - r0, NW);
    chk(rises == 1 && rise_busy == 0, "R7 one end interrupt", {rises, rise_busy}, 2);

    // R9: clear coincides with new end request
    clr_at_next = 1;
    run_chain(8'h30, 0);
    clear_irq();
    chk(irq_pending == 0, "R9 clear after collision", irq_pending, 0);

    // R8: masked
    irq_mask = 1; rises = 0; s0 = starts;
    run_chain(8'h10, 1);
    chk(starts - s0 == 3, "R8 transfers continue", starts - s0, 3);
    chk(rises == 0 && irq_pending == 0, "R8 masked", {rises, irq_pending}, 0);
    irq_mask = 0;

    // R10: stray start and done during fetch, done while idle
    s0 = starts;
    expect_chain(8'h20, 1);
    @(negedge clk); init_ptr = AW'(8'h20); chain_en = 1; start = 1;
    @(negedge clk); start = 0;
    @(negedge clk); start = 1; init_ptr = AW'(8'h10); force_done = 1;
    @(negedge clk); start = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(starts - s0 == 2, "R10 stray start/done ignored", starts - s0, 2);
    chk(exp_q.size() == 0, "R10 queue drained", exp_q.size(), 0);
    s0 = starts;
    force_done = 1;
    repeat (4) @(negedge clk);
    chk(starts == s0 && !busy, "R10 idle done ignored", {starts - s0, busy}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule